// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer of 512 words of 18 bits. The write side and the read side each run on their own clock. Data enters on a write-clock edge when the write enable is low, and it leaves on a read-clock edge when the read enable is low. The write and read pointers cross between the two clock domains as Gray codes through two-flop synchronizers. Full is kept in the write domain and empty in the read domain.

Five status flags report the fill level: full, almost-full, half-full, almost-empty and empty. The two "almost" distances come out of reset at 7 words. They can be reprogrammed through a load strobe that reuses the write port. A retransmit strobe moves the read pointer back to location zero, so that the stored data is replayed.

A mode pin is sampled while reset is held and then fixed. It selects a compatible mode or an enhanced mode. Enhanced mode adds second enables on both ports, registers the partial flags in their own clock domains, and blocks reads while the output enable is high. In compatible mode the partial flags are decoded directly from both live pointers. The output enable only forces the data output to zero; it is not a tri-state driver.

Top module: `dcf_pflag_fifo`

## Requirements
- R1: After reset, empty=1, almost-empty=1, full=0, almost-full=0 and half=0. Both offsets are 7. The mode is the value of `mode_sel` sampled while `rst_n` is low (0 = compatible, 1 = enhanced).
- R2: Words are read out in the order they were written, with all 18 bits intact. Each read-clock edge that performs a read updates `rd_data` with the next word. The write pointer only ever advances by one.
- R3: A write while full is discarded and does not change stored data. A read while empty leaves the read pointer and `rd_data` unchanged.
- R4: `full` is 1 once 512 words are stored. `empty` is 1 once no words are stored, as seen after pointer synchronization.
- R5: `half` is 1 when more than 256 words are stored; with exactly 256 words stored it is 0.
- R6: `aempty` is 1 while the stored count is at most the empty offset. `afull` is 1 while the stored count is at least 512 minus the full offset. Both offsets default to 7.
- R7: A write-clock edge with `ld_n`=0 and the write enable condition met stores `wr_data[8:0]` into an offset register and stores no word. The first load after reset sets the empty offset, the next sets the full offset, and loads keep alternating in that order.
- R8: In enhanced mode, a write or load needs both `wr_en_n` and `wr_en2_n` low, and a read needs both `rd_en_n` and `rd_en2_n` low. In compatible mode the second enables are ignored.
- R9: `rd_data` is forced to 0 while `oe_n` is 1, in both modes. In enhanced mode, a read attempted while `oe_n` is 1 does not advance the read pointer. In compatible mode it does.
- R10: `retx_n`=0 on a read-clock edge sets the read pointer to location 0 and takes priority over a read. Later reads repeat the words from the first word written after reset, as long as no more than 512 words have been written since reset.
- R11: In enhanced mode, `afull` and `half` are registered on the write clock and `aempty` is registered on the read clock. After the pointers settle, these flags report the same levels as in compatible mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous reset for both domains, active low |
| mode_sel | input | 1 | Mode select, sampled during reset (1 = enhanced) |
| wr_data | input | 18 | Write data, or offset value during a load |
| wr_en_n | input | 1 | Write enable, active low |
| wr_en2_n | input | 1 | Second write enable, enhanced mode only, active low |
| ld_n | input | 1 | Offset load, active low |
| rd_en_n | input | 1 | Read enable, active low |
| rd_en2_n | input | 1 | Second read enable, enhanced mode only, active low |
| oe_n | input | 1 | Output enable, active low |
| retx_n | input | 1 | Retransmit, active low |
| rd_data | output | 18 | Read data |
| full | output | 1 | 512 words stored |
| afull | output | 1 | Almost full |
| half | output | 1 | More than half full |
| aempty | output | 1 | Almost empty |
| empty | output | 1 | No words stored |

## Verification
The bench fills the buffer to exactly 512 words and then writes once more. A design that let that write through would overwrite the oldest unread word, and the drain that follows would show a mismatch. It steps across each flag threshold one word at a time (256/257, 504/505, 7/8, and the reprogrammed 20/21 and 481/482), so that an off-by-one comparison shows up as a wrong flag level. In enhanced mode it attempts writes with only one enable asserted and reads with the output disabled. A design that ignored the extra gating would store or consume words and shift the data order. Retransmit is issued after a full drain and the same words must come back. A design that rewound to the wrong place, or let a read win over retransmit, would return the wrong sequence.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    typedef enum logic {
        MODE_COMPAT = 1'b0,
        MODE_ENH    = 1'b1
    } dcf_mode_e;
endpackage

// File: rtl/dcf_ptr_sync.sv
// Two-flop synchronizer for a Gray-coded pointer; converts to binary on the destination side.
module dcf_ptr_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = gray_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    always_comb begin
        logic [W-1:0] b;
        b[W-1] = sync_q.s2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ sync_q.s2[i];
        end
        bin_out = b;
    end
endmodule

// File: rtl/dcf_ram.sv
// Dual-port storage: written on the write clock, read into a register on the read clock.
module dcf_ram #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 9
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb rdata_d = re ? mem[raddr] : rdata_q;

    always_ff @(posedge rd_clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-domain control: write pointer, offset registers, full and registered partial flags.
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int DATA_W  = 18,
    parameter int ADDR_W  = 9,
    parameter int OFF_DEF = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_in,
    input  logic              en_n,
    input  logic              en2_n,
    input  logic              ld_n,
    input  logic [DATA_W-1:0] data,
    input  logic [ADDR_W:0]   rbin_sync,
    output logic [ADDR_W:0]   wbin,
    output logic [ADDR_W:0]   wgray,
    output logic              push,
    output logic              mode_enh,
    output logic              full,
    output logic              afull_reg,
    output logic              half_reg,
    output logic [ADDR_W-1:0] ae_off,
    output logic [ADDR_W-1:0] af_off
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1) << ADDR_W;
    localparam logic [PW-1:0] HALF_P  = PW'(1) << (ADDR_W - 1);

    typedef struct packed {
        dcf_mode_e         mode;
        logic              ld_sel;
        logic [ADDR_W-1:0] ae_off;
        logic [ADDR_W-1:0] af_off;
        logic [PW-1:0]     wbin;
        logic [PW-1:0]     wgray;
        logic              full;
        logic              afull;
        logic              half;
    } wr_st_t;

    wr_st_t st_d, st_q;
    logic   en_ok, load;
    logic [PW-1:0] cnt;

    always_comb begin
        st_d  = st_q;
        en_ok = !en_n && (st_q.mode == MODE_COMPAT || !en2_n);
        load  = en_ok && !ld_n;
        push  = en_ok && ld_n && !st_q.full;
        if (load) begin
            if (st_q.ld_sel) st_d.af_off = data[ADDR_W-1:0];
            else             st_d.ae_off = data[ADDR_W-1:0];
            st_d.ld_sel = !st_q.ld_sel;
        end
        if (push) st_d.wbin = st_q.wbin + PW'(1);
        st_d.wgray = st_d.wbin ^ (st_d.wbin >> 1);
        cnt        = st_d.wbin - rbin_sync;
        st_d.full  = (cnt == DEPTH_P);
        st_d.afull = (cnt >= DEPTH_P - {1'b0, st_d.af_off});
        st_d.half  = (cnt > HALF_P);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: dcf_mode_e'(mode_in), ld_sel: 1'b0,
                      ae_off: ADDR_W'(OFF_DEF), af_off: ADDR_W'(OFF_DEF),
                      wbin: '0, wgray: '0, full: 1'b0, afull: 1'b0, half: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wbin      = st_q.wbin;
    assign wgray     = st_q.wgray;
    assign mode_enh  = (st_q.mode == MODE_ENH);
    assign full      = st_q.full;
    assign afull_reg = st_q.afull;
    assign half_reg  = st_q.half;
    assign ae_off    = st_q.ae_off;
    assign af_off    = st_q.af_off;
endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-domain control: read pointer, retransmit, empty and registered almost-empty.
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_in,
    input  logic              en_n,
    input  logic              en2_n,
    input  logic              oe_n,
    input  logic              rt_n,
    input  logic [ADDR_W:0]   wbin_sync,
    input  logic [ADDR_W-1:0] ae_off,
    output logic [ADDR_W:0]   rbin,
    output logic [ADDR_W:0]   rgray,
    output logic              pop,
    output logic              mode_enh,
    output logic              empty,
    output logic              aempty_reg
);
    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        dcf_mode_e     mode;
        logic [PW-1:0] rbin;
        logic [PW-1:0] rgray;
        logic          empty;
        logic          aempty;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic   en_ok;
    logic [PW-1:0] cnt;

    always_comb begin
        st_d  = st_q;
        en_ok = !en_n && (st_q.mode == MODE_COMPAT || (!en2_n && !oe_n));
        pop   = en_ok && !st_q.empty && rt_n;
        if (!rt_n)    st_d.rbin = '0;
        else if (pop) st_d.rbin = st_q.rbin + PW'(1);
        st_d.rgray  = st_d.rbin ^ (st_d.rbin >> 1);
        cnt         = wbin_sync - st_d.rbin;
        st_d.empty  = (cnt == '0);
        st_d.aempty = (cnt <= {1'b0, ae_off});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: dcf_mode_e'(mode_in), rbin: '0, rgray: '0,
                      empty: 1'b1, aempty: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rbin       = st_q.rbin;
    assign rgray      = st_q.rgray;
    assign mode_enh   = (st_q.mode == MODE_ENH);
    assign empty      = st_q.empty;
    assign aempty_reg = st_q.aempty;
endmodule

// File: rtl/dcf_pflag_fifo.sv
module dcf_pflag_fifo #(
    parameter int DATA_W  = 18,
    parameter int ADDR_W  = 9,
    parameter int OFF_DEF = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en_n,
    input  logic              wr_en2_n,
    input  logic              ld_n,
    input  logic              rd_en_n,
    input  logic              rd_en2_n,
    input  logic              oe_n,
    input  logic              retx_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              afull,
    output logic              half,
    output logic              aempty,
    output logic              empty
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1) << ADDR_W;
    localparam logic [PW-1:0] HALF_P  = PW'(1) << (ADDR_W - 1);

    logic [PW-1:0]     wbin, wgray, rbin, rgray, wbin_rs, rbin_ws, cnt_raw;
    logic              push, pop, wmode, rmode, afull_reg, half_reg, aempty_reg;
    logic [ADDR_W-1:0] ae_off, af_off;
    logic [DATA_W-1:0] ram_q;

    dcf_wr_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_DEF(OFF_DEF)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .mode_in(mode_sel), .en_n(wr_en_n),
        .en2_n(wr_en2_n), .ld_n(ld_n), .data(wr_data), .rbin_sync(rbin_ws),
        .wbin(wbin), .wgray(wgray), .push(push), .mode_enh(wmode), .full(full),
        .afull_reg(afull_reg), .half_reg(half_reg), .ae_off(ae_off), .af_off(af_off)
    );

    dcf_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .mode_in(mode_sel), .en_n(rd_en_n),
        .en2_n(rd_en2_n), .oe_n(oe_n), .rt_n(retx_n), .wbin_sync(wbin_rs),
        .ae_off(ae_off), .rbin(rbin), .rgray(rgray), .pop(pop),
        .mode_enh(rmode), .empty(empty), .aempty_reg(aempty_reg)
    );

    dcf_ptr_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_rs)
    );

    dcf_ptr_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_ws)
    );

    dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk(wr_clk), .we(push), .waddr(wbin[ADDR_W-1:0]), .wdata(wr_data),
        .rd_clk(rd_clk), .rst_n(rst_n), .re(pop), .raddr(rbin[ADDR_W-1:0]),
        .rdata(ram_q)
    );

    // Compatible mode: partial flags decoded from both live pointers, without registers
    always_comb begin
        cnt_raw = wbin - rbin;
        afull   = wmode ? afull_reg  : (cnt_raw >= DEPTH_P - {1'b0, af_off});
        half    = wmode ? half_reg   : (cnt_raw > HALF_P);
        aempty  = rmode ? aempty_reg : (cnt_raw <= {1'b0, ae_off});
        rd_data = oe_n ? '0 : ram_q;
    end
endmodule

// File: rtl/dcf_pflag_fifo_chk.sv
module dcf_pflag_fifo_chk #(
    parameter int PW = 10
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          retx_n,
    input logic          wr_en2_n,
    input logic          full,
    input logic          empty,
    input logic          wmode,
    input logic [PW-1:0] wbin,
    input logic [PW-1:0] rbin
);
    // R3: nothing enters while full
    p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |=> wbin == $past(wbin));

    // R3: the read pointer holds while empty and no retransmit is requested
    p_no_underflow_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && retx_n) |=> rbin == $past(rbin));

    // R10: retransmit rewinds the read pointer to location zero
    p_retx_rewind_r10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !retx_n |=> rbin == '0);

    // R2: the write pointer only ever advances by one
    p_wr_step_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wbin != $past(wbin)) |-> (wbin == $past(wbin) + PW'(1)));

    // R8: in enhanced mode a write needs the second enable too
    p_enh_wr_gate_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wmode && wr_en2_n) |=> wbin == $past(wbin));
endmodule

bind dcf_pflag_fifo dcf_pflag_fifo_chk #(.PW(ADDR_W + 1)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .retx_n(retx_n),
    .wr_en2_n(wr_en2_n), .full(full), .empty(empty), .wmode(wmode),
    .wbin(wbin), .rbin(rbin)
);

// File: tb/dcf_pflag_fifo_bench.sv
module dcf_pflag_fifo_bench;
    logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0, mode_sel = 1'b0;
    logic [17:0] wr_data = '0, rd_data;
    logic        wr_en_n = 1'b1, wr_en2_n = 1'b1, ld_n = 1'b1;
    logic        rd_en_n = 1'b1, rd_en2_n = 1'b1, oe_n = 1'b1, retx_n = 1'b1;
    logic        full, afull, half, aempty, empty;
    logic        enh = 1'b0;
    logic [17:0] exp_q[$], hist[$];
    logic [17:0] mon_e, last_q;
    int          n_chk = 0, n_fail = 0;

    dcf_pflag_fifo u_dcf_pflag_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .wr_data(wr_data), .wr_en_n(wr_en_n), .wr_en2_n(wr_en2_n), .ld_n(ld_n),
        .rd_en_n(rd_en_n), .rd_en2_n(rd_en2_n), .oe_n(oe_n), .retx_n(retx_n),
        .rd_data(rd_data), .full(full), .afull(afull), .half(half),
        .aempty(aempty), .empty(empty)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: every accepted write becomes an expected item
    always @(posedge wr_clk) begin
        if (rst_n && !wr_en_n && (!enh || !wr_en2_n) && ld_n && !full) begin
            exp_q.push_back(wr_data);
            hist.push_back(wr_data);
        end
    end

    // Monitor: pops and compares on every read the requirements say takes place
    always @(posedge rd_clk) begin
        if (rst_n) begin
            if (!retx_n) begin
                exp_q = hist;
            end else if (!rd_en_n && (!enh || (!rd_en2_n && !oe_n)) && !empty) begin
                mon_e = (exp_q.size() > 0) ? exp_q.pop_front() : 18'h3ffff;
                #1;
                chk("R2 read data", {14'd0, rd_data}, oe_n ? 32'd0 : {14'd0, mon_e});
            end
        end
    end

    task automatic do_reset(input logic m);
        rst_n = 1'b0; mode_sel = m; enh = m;
        wr_en_n = 1'b1; ld_n = 1'b1; rd_en_n = 1'b1; retx_n = 1'b1;
        wr_en2_n = m ? 1'b0 : 1'b1; rd_en2_n = m ? 1'b0 : 1'b1; oe_n = 1'b0;
        repeat (4) @(posedge wr_clk);
        exp_q.delete(); hist.delete();
        @(negedge wr_clk) rst_n = 1'b1;
        repeat (2) @(negedge wr_clk);
    endtask

    task automatic write_n(input int count, input logic [17:0] base);
        @(negedge wr_clk);
        for (int i = 0; i < count; i++) begin
            wr_data = base + 18'(i); wr_en_n = 1'b0;
            @(negedge wr_clk);
        end
        wr_en_n = 1'b1;
    endtask

    task automatic read_n(input int count);
        @(negedge rd_clk);
        rd_en_n = 1'b0;
        repeat (count) @(negedge rd_clk);
        rd_en_n = 1'b1;
    endtask

    task automatic load_off(input logic [17:0] v);
        @(negedge wr_clk);
        ld_n = 1'b0; wr_en_n = 1'b0; wr_data = v;
        @(negedge wr_clk);
        ld_n = 1'b1; wr_en_n = 1'b1;
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
        @(negedge wr_clk);
    endtask

    task automatic chk_flags(input string req, input logic f, input logic af,
                             input logic h, input logic ae, input logic e);
        chk({req, " full"}, {31'd0, full}, {31'd0, f});
        chk({req, " afull"}, {31'd0, afull}, {31'd0, af});
        chk({req, " half"}, {31'd0, half}, {31'd0, h});
        chk({req, " aempty"}, {31'd0, aempty}, {31'd0, ae});
        chk({req, " empty"}, {31'd0, empty}, {31'd0, e});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state, compatible mode
        do_reset(1'b0);
        chk_flags("R1 reset", 0, 0, 0, 1, 1);

        // R8: compatible mode ignores the second enable (held high here); R6 default offset 7
        write_n(7, 18'h100);
        settle();
        chk_flags("R6 seven stored", 0, 0, 0, 1, 0);
        write_n(1, 18'h107);
        settle();
        chk("R6 eight stored aempty", {31'd0, aempty}, 32'd0);
        chk("R8 compat second enable ignored", {31'd0, empty}, 32'd0);
        read_n(8);
        settle();
        chk_flags("R4 drained", 0, 0, 0, 1, 1);

        // R5 half boundary, R6 almost-full boundary, R4 full, R3 overflow
        write_n(256, 18'h1000);
        settle();
        chk("R5 256 stored half", {31'd0, half}, 32'd0);
        write_n(1, 18'h2000);
        settle();
        chk("R5 257 stored half", {31'd0, half}, 32'd1);
        write_n(247, 18'h2100);
        settle();
        chk("R6 504 stored afull", {31'd0, afull}, 32'd0);
        write_n(1, 18'h2200);
        settle();
        chk("R6 505 stored afull", {31'd0, afull}, 32'd1);
        write_n(7, 18'h2300);
        settle();
        chk_flags("R4 full", 1, 1, 1, 0, 0);
        write_n(1, 18'h3ffff);
        read_n(512);
        settle();
        chk_flags("R3 drained after overflow", 0, 0, 0, 1, 1);
        last_q = rd_data;
        read_n(3);
        settle();
        chk("R3 empty read ignored", {14'd0, rd_data}, {14'd0, last_q});
        write_n(1, 18'h0abc);
        settle();
        read_n(1);
        settle();

        // R7: loads set the empty offset first, then the full offset
        load_off(18'd20);
        load_off(18'd30);
        settle();
        chk("R7 load stores no word", {31'd0, empty}, 32'd1);
        write_n(20, 18'h500);
        settle();
        chk("R7 empty offset 20 aempty", {31'd0, aempty}, 32'd1);
        write_n(1, 18'h600);
        settle();
        chk("R7 21 stored aempty", {31'd0, aempty}, 32'd0);
        write_n(460, 18'h700);
        settle();
        chk("R7 full offset 30 at 481", {31'd0, afull}, 32'd0);
        write_n(1, 18'h900);
        settle();
        chk("R7 full offset 30 at 482", {31'd0, afull}, 32'd1);
        read_n(482);
        settle();

        // R10 retransmit; R9 compat read with output disabled still consumes, data reads as zero
        do_reset(1'b0);
        write_n(5, 18'h3a0);
        settle();
        oe_n = 1'b1;
        read_n(5);
        oe_n = 1'b0;
        settle();
        chk("R9 compat read advances", {31'd0, empty}, 32'd1);
        @(negedge rd_clk) retx_n = 1'b0;
        @(negedge rd_clk) retx_n = 1'b1;
        settle();
        chk("R10 retransmit refills", {31'd0, empty}, 32'd0);
        read_n(5);
        settle();
        chk("R10 drained again", {31'd0, empty}, 32'd1);

        // Enhanced mode: R8 second enables, R9 read suppression, R11 registered flags
        do_reset(1'b1);
        chk_flags("R1 reset enhanced", 0, 0, 0, 1, 1);
        wr_en2_n = 1'b1;
        write_n(3, 18'h0dead);
        settle();
        chk("R8 enh write needs both enables", {31'd0, empty}, 32'd1);
        wr_en2_n = 1'b0;
        write_n(7, 18'h0c00);
        settle();
        chk_flags("R11 enh seven stored", 0, 0, 0, 1, 0);
        write_n(3, 18'h0c07);
        settle();
        chk("R11 enh ten stored aempty", {31'd0, aempty}, 32'd0);
        rd_en2_n = 1'b1;
        read_n(2);
        rd_en2_n = 1'b0;
        oe_n = 1'b1;
        read_n(2);
        chk("R9 output gated to zero", {14'd0, rd_data}, 32'd0);
        oe_n = 1'b0;
        settle();
        read_n(10);
        settle();
        chk("R9 enh suppressed reads kept data", {31'd0, empty}, 32'd1);
        write_n(257, 18'h4000);
        settle();
        chk_flags("R11 enh 257 stored", 0, 0, 1, 0, 0);
        read_n(257);
        settle();
        chk("R11 enh drained", {31'd0, empty}, 32'd1);

        finish_run();
    end
endmodule